// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. Each request line is captured into a request register. A per-input trigger-mode register chooses how each line is captured. An edge-mode input latches a request when its level rises. A level-mode input makes its request bit follow the line. Pending requests are the request bits that the mask leaves through. They are scanned in a priority order that starts at a stored base and wraps around.

The block tracks which inputs are in service. It raises its interrupt output only when the best pending request strictly outranks the best in-service one. On a master instance, special fully nested operation can leave the cascade input out of that comparison. An acknowledge strobe accepts the current winner:

- It marks the winner in service, unless auto end-of-interrupt is on.
- It drops the request bit only for an edge-mode input.
- It can rotate the priority base to just past the winner.

Top module: `irq_resolver`

## Requirements
- R1: After a synchronous reset, `int_out` is 0, `win_id` is 0, and `irr_out`, `isr_out` and the priority base are all 0.
- R2: For an edge-mode input (trigger bit 0), the request bit is set on a cycle where the input is 1 and its recorded level from the cycle before was 0. An input that stays high does not set the bit again once it has been cleared.
- R3: For a level-mode input (trigger bit 1), the request bit takes the input level at each clock edge, so it clears when the input goes low.
- R4: A request whose `mask_in` bit is 1 is not pending and never drives `int_out` or `win_id`.
- R5: The winner is the pending input i with the smallest (i - base) mod 8. `int_out`/`win_id` are registered: they reflect the request register one clock after it updates. With no interrupt raised, `win_id` is 0.
- R6: `int_out` is 1 only if the winner's rotated priority is strictly smaller than the smallest rotated priority among the in-service bits. A pending input equal in priority to one in service is blocked.
- R7: On a master instance with `sfnm_en` = 1, in-service bit 2 is left out of the comparison in R6.
- R8: An `ack` while an interrupt is requested sets the winner's in-service bit. It clears the winner's request bit only if that input is edge-mode; a level-mode request stays set while its input is high.
- R9: With `auto_eoi_en` = 1, an `ack` leaves `isr_out` unchanged.
- R10: With `auto_eoi_en` = 1 and `rot_aeoi_en` = 1, an `ack` sets the priority base to (winner + 1) mod 8.
- R11: A write to the trigger-mode register changes only the writable bits: mask 0xF8 on a master, 0xDE on a slave. Reset does not alter the trigger-mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Interrupt request lines |
| mask_in | input | 8 | Mask bits, 1 blocks the input |
| trig_we | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| sfnm_en | input | 1 | Special fully nested operation (master only) |
| auto_eoi_en | input | 1 | Acknowledge does not mark in service |
| rot_aeoi_en | input | 1 | Rotate priority base on auto end-of-interrupt |
| ack | input | 1 | Acknowledge strobe, one cycle |
| int_out | output | 1 | Registered interrupt request |
| win_id | output | 3 | Registered winning input number |
| irr_out | output | 8 | Request register |
| isr_out | output | 8 | In-service register |
| trig_out | output | 8 | Trigger-mode register |

## Verification
The assertions assume the following about the inputs:

- `ack` is a single-cycle strobe.
- `mask_in` and the mode bits are stable signals whose value at an edge is the value that counts.
- `req_in` changes only between edges.

The stimulus drives every input on the falling edge. It pulses `ack` only while `int_out` is high. It holds the mode bits constant across each acknowledge. Most directed scenarios start from a reset, so the in-service state never needs an end-of-interrupt path to clear.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  parameter int unsigned IRQ_LINES   = 8;
  parameter int unsigned IRQ_IDW     = $clog2(IRQ_LINES);
  parameter logic [7:0]  MASTER_WMSK = 8'hF8;
  parameter logic [7:0]  SLAVE_WMSK  = 8'hDE;
  parameter int unsigned CASCADE_IN  = 2;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_q,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] last_lvl;

  always_ff @(posedge clk) begin
    if (rst) last_lvl <= '0;
    else     last_lvl <= req_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                            irr_q[i] <= 1'b0;
      else if (trig_q[i])                 irr_q[i] <= req_in[i];
      else if (req_in[i] && !last_lvl[i]) irr_q[i] <= 1'b1;
      else if (ack_clr[i])                irr_q[i] <= 1'b0;
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
      (!trig_q[i] && req_in[i] && !last_lvl[i]) |=> irr_q[i]); // R2
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      trig_q[i] |=> (irr_q[i] == $past(req_in[i]))); // R3
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned N   = 8,
  parameter int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   vec,
  input  logic [IDW-1:0] base,
  output logic [IDW:0]   prio,
  output logic [IDW-1:0] id
);
  always_comb begin
    logic [IDW-1:0] idx;
    prio = (IDW+1)'(N);
    id   = '0;
    for (int p = N - 1; p >= 0; p--) begin
      idx = base + IDW'(p);
      if (vec[idx]) begin
        prio = (IDW+1)'(p);
        id   = idx;
      end
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned N          = IRQ_LINES,
  parameter bit          IS_MASTER  = 1'b1,
  parameter logic [N-1:0] TRIG_WMASK = N'(MASTER_WMSK),
  parameter int unsigned CASC_IN    = CASCADE_IN,
  localparam int unsigned IDW       = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req_in,
  input  logic [N-1:0]   mask_in,
  input  logic           trig_we,
  input  logic [N-1:0]   trig_wdata,
  input  logic           sfnm_en,
  input  logic           auto_eoi_en,
  input  logic           rot_aeoi_en,
  input  logic           ack,
  output logic           int_out,
  output logic [IDW-1:0] win_id,
  output logic [N-1:0]   irr_out,
  output logic [N-1:0]   isr_out,
  output logic [N-1:0]   trig_out
);
  logic [N-1:0]   trig_q = '0;
  logic [N-1:0]   irr_q, isr_q, isr_eff, pend, casc_bit, ack_clr, win_oh;
  logic [IDW-1:0] base_q, win_c, cur_id;
  logic [IDW:0]   pprio, cprio;
  logic           req_c, ack_take, int_q;
  logic [IDW-1:0] win_q;

  // trigger-mode register: no reset, only writable bits change
  always_ff @(posedge clk) begin
    if (trig_we) trig_q <= (trig_q & ~TRIG_WMASK) | (trig_wdata & TRIG_WMASK);
  end

  if (IS_MASTER) begin : g_casc
    assign casc_bit = sfnm_en ? (N'(1) << CASC_IN) : '0;
  end else begin : g_nocasc
    assign casc_bit = '0;
  end

  assign pend     = irr_q & ~mask_in;
  assign isr_eff  = isr_q & ~casc_bit;
  assign req_c    = pprio < cprio;
  assign ack_take = ack && req_c;
  assign win_oh   = N'(1) << win_c;
  assign ack_clr  = ack_take ? (win_oh & ~trig_q) : '0;

  irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_q(trig_q),
    .ack_clr(ack_clr), .irr_q(irr_q)
  );

  irq_prio_scan #(.N(N), .IDW(IDW)) u_pend_scan (
    .vec(pend), .base(base_q), .prio(pprio), .id(win_c)
  );

  irq_prio_scan #(.N(N), .IDW(IDW)) u_isr_scan (
    .vec(isr_eff), .base(base_q), .prio(cprio), .id(cur_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
      int_q  <= 1'b0;
      win_q  <= '0;
    end else begin
      if (ack_take) begin
        if (!auto_eoi_en)     isr_q  <= isr_q | win_oh;
        else if (rot_aeoi_en) base_q <= win_c + 1'b1;
      end
      int_q <= req_c;
      win_q <= req_c ? win_c : '0;
    end
  end

  assign int_out  = int_q;
  assign win_id   = win_q;
  assign irr_out  = irr_q;
  assign isr_out  = isr_q;
  assign trig_out = trig_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isr_q == '0 && base_q == '0 && !int_q && win_q == '0)); // R1
  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (rst)
    int_q |-> ((($past(mask_in) >> win_q) & N'(1)) == '0)); // R4
  AST_STRICT_BEAT: assert property (@(posedge clk) disable iff (rst)
    int_q |-> ((($past(isr_eff) >> win_q) & N'(1)) == '0)); // R6
  AST_ACK_MARKS: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !auto_eoi_en) |=> isr_q[$past(win_c)]); // R8
  AST_ACK_LEVEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ack_take && trig_q[win_c] && req_in[win_c]) |=> irr_q[$past(win_c)]); // R8
  AST_AEOI_ISR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ack && auto_eoi_en) |=> $stable(isr_q)); // R9
  AST_ROTATE_BASE: assert property (@(posedge clk) disable iff (rst)
    (ack_take && auto_eoi_en && rot_aeoi_en) |=> (base_q == IDW'($past(win_c) + 1'b1))); // R10
endmodule

// File: tb/tb_irq_resolver.sv
module tb_irq_resolver;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_in, mask_in, trig_wdata;
  logic       trig_we, sfnm_en, auto_eoi_en, rot_aeoi_en, ack;
  logic       int_out;
  logic [2:0] win_id;
  logic [7:0] irr_out, isr_out, trig_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_resolver dut (
    .clk(clk), .rst(rst), .req_in(req_in), .mask_in(mask_in),
    .trig_we(trig_we), .trig_wdata(trig_wdata), .sfnm_en(sfnm_en),
    .auto_eoi_en(auto_eoi_en), .rot_aeoi_en(rot_aeoi_en), .ack(ack),
    .int_out(int_out), .win_id(win_id), .irr_out(irr_out),
    .isr_out(isr_out), .trig_out(trig_out)
  );

  // {req, mask, expected int, expected id}; trig = F8 (bits 3..7 level)
  localparam logic [19:0] VEC [8] = '{
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h0C, 8'h00, 1'b1, 3'd2},
    {8'h0C, 8'h04, 1'b1, 3'd3},
    {8'hF0, 8'h00, 1'b1, 3'd4},
    {8'h80, 8'h80, 1'b0, 3'd0},
    {8'hA0, 8'h20, 1'b1, 3'd7},
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'hFF, 8'h7F, 1'b1, 3'd7}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_in = '0; ack = 1'b0;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    req_in = '0; mask_in = '0; trig_we = 1'b0; trig_wdata = '0;
    sfnm_en = 1'b0; auto_eoi_en = 1'b0; rot_aeoi_en = 1'b0; ack = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    step(2);
    rst = 1'b0;
    step(1);
    check("R1 int", int_out, 0);
    check("R1 id", win_id, 0);
    check("R1 irr", irr_out, 0);
    check("R1 isr", isr_out, 0);

    // R11 writable mask, survives reset
    trig_we = 1'b1; trig_wdata = 8'hFF;
    step(1);
    trig_we = 1'b0;
    check("R11 trig write", trig_out, 8'hF8);
    do_reset();
    check("R11 trig after reset", trig_out, 8'hF8);

    // table: R4, R5
    foreach (VEC[k]) begin
      do_reset();
      req_in = VEC[k][19:12]; mask_in = VEC[k][11:4];
      step(2);
      check($sformatf("R5/R4 vec%0d int", k), int_out, VEC[k][3]);
      check($sformatf("R5/R4 vec%0d id", k), win_id, VEC[k][2:0]);
    end
    mask_in = '0;

    // R2 + R8 edge input
    do_reset();
    req_in = 8'h02;
    step(1);
    check("R2 edge latch", irr_out, 8'h02);
    step(1);
    check("R5 int edge", int_out, 1);
    pulse_ack();
    check("R8 edge irr cleared", irr_out, 8'h00);
    check("R8 isr set", isr_out, 8'h02);
    step(3);
    check("R2 held high no relatch", irr_out, 8'h00);

    // R3 + R8 + R6 level input
    do_reset();
    req_in = 8'h10;
    step(1);
    check("R3 level set", irr_out, 8'h10);
    req_in = 8'h00;
    step(1);
    check("R3 level clear", irr_out, 8'h00);
    req_in = 8'h10;
    step(2);
    pulse_ack();
    check("R8 level isr", isr_out, 8'h10);
    check("R8 level irr kept", irr_out, 8'h10);
    step(1);
    check("R6 equal blocked", int_out, 0);
    req_in = 8'h30;
    step(2);
    check("R6 lower blocked", int_out, 0);
    req_in = 8'h18;
    step(2);
    check("R6 higher int", int_out, 1);
    check("R6 higher id", win_id, 3);

    // R7 cascade exemption
    do_reset();
    req_in = 8'h04;
    step(2);
    pulse_ack();
    check("R7 isr2", isr_out, 8'h04);
    req_in = 8'h00;
    step(1);
    req_in = 8'h04;
    step(2);
    check("R7 blocked without sfnm", int_out, 0);
    sfnm_en = 1'b1;
    step(2);
    check("R7 int with sfnm", int_out, 1);
    check("R7 id with sfnm", win_id, 2);
    sfnm_en = 1'b0;

    // R9 auto-EOI
    do_reset();
    auto_eoi_en = 1'b1;
    req_in = 8'h20;
    step(2);
    pulse_ack();
    check("R9 isr untouched", isr_out, 8'h00);
    step(1);
    check("R9 int remains", int_out, 1);

    // R10 rotation
    do_reset();
    rot_aeoi_en = 1'b1;
    req_in = 8'h48;
    step(2);
    check("R10 base0 id", win_id, 3);
    pulse_ack();
    step(1);
    check("R10 base4 id", win_id, 6);
    pulse_ack();
    step(1);
    check("R10 base7 id", win_id, 3);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule